// File: doc/BRIEF.md
# Flash Instruction Line Prefetcher

This block sits between a processor's instruction fetch port and a slow, wide memory array. The array returns one 128-bit line per read and needs a programmable number of wait states. The block keeps the most recently demanded line in a current-line buffer. It serves 32-bit or 16-bit instruction words from that buffer in the same cycle they are requested, so the processor waits only when the line is not held.

When prefetch is enabled, the block reads the next sequential line into a second buffer while the processor is still working through the current one. A fetch that reaches that line moves it into the current buffer and starts the read of the line after it. A fetch to any other line is treated as a branch: the speculative line is dropped and a demand read stalls the processor for the full configured latency.

The wait-state count is written through a small configuration port. A new value is applied only when no array read is in progress. The read-back field shows the value actually in force, so software can poll it until the change has landed.

Top module: `flash_line_prefetch`

## Requirements
- R1: After reset, cpu_valid and mem_req are low, cfg_ws_rd reads 0, prefetch issues no array read, and neither line buffer holds a line.
- R2: mem_line_addr carries byte address bits [31:4]. For a 32-bit fetch (cpu_half=0), cpu_rdata is line bits [32k+31:32k] with k = cpu_addr[3:2]. For a 16-bit fetch (cpu_half=1), cpu_rdata is line bits [16j+15:16j] with j = cpu_addr[3:1], zero-extended to 32 bits.
- R3: A fetch whose line is in the current buffer gives cpu_valid in the same cycle the request is presented.
- R4: A fetch to a line that is neither buffered nor being read raises mem_req on the next cycle. mem_req stays high with a stable mem_line_addr for WS+1 cycles, where WS is the wait-state count in force. With mem_ready high, cpu_valid follows WS+2 cycles after the request was first presented.
- R5: While mem_ready is low in the final cycle of a read, the read does not complete: mem_req stays high and cpu_valid stays low. The read completes in the first such cycle with mem_ready high.
- R6: With prefetch enabled, a valid current line, an empty prefetch buffer and no read in progress, the block starts a read of the line at current index + 1 on the next cycle.
- R7: A fetch that hits the prefetch buffer is answered in the same cycle. That line becomes the current line, and a read of the following line starts one cycle after the hit cycle.
- R8: A fetch to a line outside both buffers, and not being read, aborts a prefetch read in progress and discards a completed prefetched line. The demand read's address appears on the next cycle.
- R9: A fetch to the line that an ongoing prefetch read is fetching waits for that read instead of restarting it. cpu_valid arrives one cycle after the read completes.
- R10: A wait-state write is applied at the edge that ends its cycle if no read is in progress in that cycle. Otherwise it is held and applied at the edge that ends the first cycle without a read. cfg_ws_rd always shows the applied value, and a read in progress keeps the value it started with.
- R11: With prefetch disabled, mem_req rises only for demand reads.
- R12: With zero wait states, fetches return correct data with prefetch on or off. A demand miss takes 2 cycles, and a prefetched line is hit with no wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Fetch request, held until cpu_valid |
| cpu_addr | input | 32 | Fetch byte address |
| cpu_half | input | 1 | 1 selects a 16-bit fetch, 0 a 32-bit fetch |
| cpu_valid | output | 1 | Fetch data valid this cycle |
| cpu_rdata | output | 32 | Fetched instruction word |
| mem_req | output | 1 | Array line read in progress |
| mem_line_addr | output | 28 | Line index of the read |
| mem_ready | input | 1 | Array can complete the read this cycle |
| mem_rdata | input | 128 | Line data from the array |
| cfg_ws_wr | input | 1 | Write strobe for the wait-state count |
| cfg_ws_wdata | input | 3 | New wait-state count |
| cfg_pf_en | input | 1 | Prefetch enable |
| cfg_ws_rd | output | 3 | Wait-state count in force |

## Verification
The hardest situations to reach from the ports are the ones where the processor's request collides with a speculative read. A branch can land while a prefetch is mid-flight. A fetch can target the very line still being prefetched. A wait-state write can arrive while a read is busy. Directed sequences set these up by counting cycles from a known hit: enabling prefetch, idling a fixed number of cycles so that a prefetch is running or has finished, then issuing the colliding fetch. Seeded random traffic then mixes sequential runs, branches, both fetch widths, toggled wait states and a stalling mem_ready, and checks every returned word against a model of the array.

// File: rtl/flp_pkg.sv
package flp_pkg;
  typedef enum logic {
    RD_DEMAND   = 1'b0,
    RD_PREFETCH = 1'b1
  } rd_kind_e;

  localparam int SLOT_CUR = 0;
  localparam int SLOT_PF  = 1;
  localparam int N_SLOTS  = 2;
endpackage

// File: rtl/flp_ws_ctrl.sv
module flp_ws_ctrl #(
  parameter int WS_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [WS_W-1:0] wdata,
  input  logic            busy,
  output logic [WS_W-1:0] ws_act
);
  logic [WS_W-1:0] act_q, act_n;
  logic [WS_W-1:0] pval_q, pval_n;
  logic            pend_q, pend_n;
  logic            want;
  logic [WS_W-1:0] target;

  assign want   = wr | pend_q;
  assign target = wr ? wdata : pval_q;

  always_comb begin
    act_n  = act_q;
    pval_n = pval_q;
    pend_n = pend_q;
    if (want && !busy) begin
      act_n  = target;
      pend_n = 1'b0;
    end else if (wr) begin
      pval_n = wdata;
      pend_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= '0;
      pval_q <= '0;
      pend_q <= 1'b0;
    end else begin
      act_q  <= act_n;
      pval_q <= pval_n;
      pend_q <= pend_n;
    end
  end

  assign ws_act = act_q;

  AST_WS_HELD_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(act_q)); // R10
  AST_PEND_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !busy) |=> !pend_q); // R10
endmodule

// File: rtl/flp_line_slot.sv
module flp_line_slot #(
  parameter int TAG_W  = 28,
  parameter int LINE_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic              clr,
  input  logic [TAG_W-1:0]  ld_tag,
  input  logic [LINE_W-1:0] ld_data,
  output logic              valid,
  output logic [TAG_W-1:0]  tag,
  output logic [LINE_W-1:0] data
);
  logic             v_q, v_n;
  logic [TAG_W-1:0] t_q;

  always_comb begin
    v_n = v_q;
    if (ld)       v_n = 1'b1;
    else if (clr) v_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= 1'b0;
      t_q <= '0;
    end else begin
      v_q <= v_n;
      if (ld) t_q <= ld_tag;
    end
  end

  always_ff @(posedge clk) begin
    if (ld) data <= ld_data;
  end

  assign valid = v_q;
  assign tag   = t_q;
endmodule

// File: rtl/flp_word_sel.sv
module flp_word_sel #(
  parameter int LINE_W = 128,
  parameter int INSN_W = 32,
  parameter int SEL_W  = 3
) (
  input  logic [LINE_W-1:0] line,
  input  logic [SEL_W-1:0]  sel,
  input  logic              half,
  output logic [INSN_W-1:0] word
);
  localparam int NW     = LINE_W / INSN_W;
  localparam int NH     = LINE_W / 16;
  localparam int WIDX_W = $clog2(NW);

  logic [INSN_W-1:0] words [NW];
  logic [15:0]       halves[NH];

  for (genvar gw = 0; gw < NW; gw++) begin : g_words
    assign words[gw] = line[gw*INSN_W +: INSN_W];
  end
  for (genvar gh = 0; gh < NH; gh++) begin : g_halves
    assign halves[gh] = line[gh*16 +: 16];
  end

  always_comb begin
    if (half) word = {{(INSN_W-16){1'b0}}, halves[sel]};
    else      word = words[sel[SEL_W-1 -: WIDX_W]];
  end
endmodule

// File: rtl/flp_read_engine.sv
module flp_read_engine
  import flp_pkg::*;
#(
  parameter int TAG_W = 28,
  parameter int WS_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [TAG_W-1:0] start_tag,
  input  rd_kind_e         start_kind,
  input  logic [WS_W-1:0]  ws_lim,
  input  logic             ready,
  output logic             busy,
  output logic [TAG_W-1:0] tag,
  output rd_kind_e         kind,
  output logic             done
);
  logic             busy_q, busy_n;
  logic [TAG_W-1:0] tag_q, tag_n;
  rd_kind_e         kind_q, kind_n;
  logic [WS_W-1:0]  cnt_q, cnt_n;

  assign done = busy_q && (cnt_q == ws_lim) && ready;

  always_comb begin
    busy_n = busy_q;
    tag_n  = tag_q;
    kind_n = kind_q;
    cnt_n  = cnt_q;
    if (start) begin
      busy_n = 1'b1;
      tag_n  = start_tag;
      kind_n = start_kind;
      cnt_n  = '0;
    end else if (done) begin
      busy_n = 1'b0;
    end else if (busy_q && (cnt_q != ws_lim)) begin
      cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      tag_q  <= '0;
      kind_q <= RD_DEMAND;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_n;
      tag_q  <= tag_n;
      kind_q <= kind_n;
      cnt_q  <= cnt_n;
    end
  end

  assign busy = busy_q;
  assign tag  = tag_q;
  assign kind = kind_q;

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !done && !start) |=> (busy_q && $stable(tag_q))); // R4
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !ready && !start) |=> busy_q); // R5
endmodule

// File: rtl/flash_line_prefetch.sv
module flash_line_prefetch
  import flp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LINE_W = 128,
  parameter int INSN_W = 32,
  parameter int WS_W   = 3,
  localparam int OFF_W = $clog2(LINE_W / 8),
  localparam int TAG_W = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_half,
  output logic              cpu_valid,
  output logic [INSN_W-1:0] cpu_rdata,
  output logic              mem_req,
  output logic [TAG_W-1:0]  mem_line_addr,
  input  logic              mem_ready,
  input  logic [LINE_W-1:0] mem_rdata,
  input  logic              cfg_ws_wr,
  input  logic [WS_W-1:0]   cfg_ws_wdata,
  input  logic              cfg_pf_en,
  output logic [WS_W-1:0]   cfg_ws_rd
);
  localparam int SEL_W = OFF_W - 1;

  logic [TAG_W-1:0]  req_tag;
  logic [SEL_W-1:0]  req_sel;
  logic              unused_addr_lsb;

  logic              slot_ld   [N_SLOTS];
  logic              slot_clr  [N_SLOTS];
  logic [TAG_W-1:0]  slot_ltag [N_SLOTS];
  logic [LINE_W-1:0] slot_ldat [N_SLOTS];
  logic              slot_v    [N_SLOTS];
  logic [TAG_W-1:0]  slot_tag  [N_SLOTS];
  logic [LINE_W-1:0] slot_data [N_SLOTS];

  logic              rd_busy, rd_done, rd_start;
  logic [TAG_W-1:0]  rd_tag, rd_start_tag, next_tag;
  rd_kind_e          rd_kind, rd_start_kind;
  logic [WS_W-1:0]   ws_act;

  logic hit_cur, hit_pf, in_flight, miss, promote, pf_go;

  assign req_tag         = cpu_addr[ADDR_W-1:OFF_W];
  assign req_sel         = cpu_addr[OFF_W-1:1];
  assign unused_addr_lsb = cpu_addr[0];
  assign next_tag        = slot_tag[SLOT_CUR] + TAG_W'(1);

  assign hit_cur   = slot_v[SLOT_CUR] && (slot_tag[SLOT_CUR] == req_tag);
  assign hit_pf    = slot_v[SLOT_PF]  && (slot_tag[SLOT_PF]  == req_tag);
  assign in_flight = rd_busy && (rd_tag == req_tag);
  assign miss      = cpu_req && !hit_cur && !hit_pf && !in_flight;
  assign promote   = cpu_req && !hit_cur && hit_pf;
  assign pf_go     = !rd_busy && cfg_pf_en && slot_v[SLOT_CUR] &&
                     !slot_v[SLOT_PF] && !miss && !promote;

  assign rd_start      = miss || pf_go;
  assign rd_start_tag  = miss ? req_tag : next_tag;
  assign rd_start_kind = miss ? RD_DEMAND : RD_PREFETCH;

  always_comb begin
    slot_ld[SLOT_CUR]   = (rd_done && rd_kind == RD_DEMAND) || promote;
    slot_clr[SLOT_CUR]  = 1'b0;
    slot_ltag[SLOT_CUR] = promote ? slot_tag[SLOT_PF]  : rd_tag;
    slot_ldat[SLOT_CUR] = promote ? slot_data[SLOT_PF] : mem_rdata;
    slot_ld[SLOT_PF]    = rd_done && (rd_kind == RD_PREFETCH) && !miss;
    slot_clr[SLOT_PF]   = miss || promote;
    slot_ltag[SLOT_PF]  = rd_tag;
    slot_ldat[SLOT_PF]  = mem_rdata;
  end

  for (genvar gs = 0; gs < N_SLOTS; gs++) begin : g_slot
    flp_line_slot #(.TAG_W(TAG_W), .LINE_W(LINE_W)) slot_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld      (slot_ld[gs]),
      .clr     (slot_clr[gs]),
      .ld_tag  (slot_ltag[gs]),
      .ld_data (slot_ldat[gs]),
      .valid   (slot_v[gs]),
      .tag     (slot_tag[gs]),
      .data    (slot_data[gs])
    );
  end

  flp_read_engine #(.TAG_W(TAG_W), .WS_W(WS_W)) eng_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (rd_start),
    .start_tag  (rd_start_tag),
    .start_kind (rd_start_kind),
    .ws_lim     (ws_act),
    .ready      (mem_ready),
    .busy       (rd_busy),
    .tag        (rd_tag),
    .kind       (rd_kind),
    .done       (rd_done)
  );

  flp_ws_ctrl #(.WS_W(WS_W)) ws_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (cfg_ws_wr),
    .wdata  (cfg_ws_wdata),
    .busy   (rd_busy),
    .ws_act (ws_act)
  );

  flp_word_sel #(.LINE_W(LINE_W), .INSN_W(INSN_W), .SEL_W(SEL_W)) sel_i (
    .line (hit_cur ? slot_data[SLOT_CUR] : slot_data[SLOT_PF]),
    .sel  (req_sel),
    .half (cpu_half),
    .word (cpu_rdata)
  );

  assign cpu_valid     = cpu_req && (hit_cur || hit_pf);
  assign mem_req       = rd_busy;
  assign mem_line_addr = rd_tag;
  assign cfg_ws_rd     = ws_act;

  AST_PF_FOLLOWS_CUR: assert property (@(posedge clk) disable iff (!rst_n)
    slot_v[SLOT_PF] |-> (slot_tag[SLOT_PF] == next_tag)); // R7
  AST_PF_NEEDS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_busy && rd_kind == RD_PREFETCH) |-> slot_v[SLOT_CUR]); // R6
  AST_PF_ONLY_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_req) && rd_kind == RD_PREFETCH) |-> $past(cfg_pf_en)); // R11
endmodule

// File: tb/flash_line_prefetch_tb.sv
module flash_line_prefetch_tb_top;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         cpu_req, cpu_half, cpu_valid;
  logic [31:0]  cpu_addr, cpu_rdata;
  logic         mem_req, mem_ready;
  logic [27:0]  mem_line_addr;
  logic [127:0] mem_rdata;
  logic         cfg_ws_wr, cfg_pf_en;
  logic [2:0]   cfg_ws_wdata, cfg_ws_rd;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  rnd_rdy = 1'b0;

  always #4 clk = ~clk;

  function automatic logic [31:0] mem_word(logic [27:0] t, int k);
    return (32'(t) * 32'h9E3779B1) ^ (32'(k) * 32'h01010101) ^ 32'h5A5A0000;
  endfunction

  function automatic logic [127:0] line_of(logic [27:0] t);
    logic [127:0] l;
    for (int k = 0; k < 4; k++) l[32*k +: 32] = mem_word(t, k);
    return l;
  endfunction

  function automatic logic [31:0] exp_fetch(logic [31:0] a, bit h);
    logic [127:0] l;
    l = line_of(a[31:4]);
    if (h) return {16'h0, l[16*a[3:1] +: 16]};
    return l[32*a[3:2] +: 32];
  endfunction

  assign mem_rdata = line_of(mem_line_addr);

  flash_line_prefetch dut_i (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_addr(cpu_addr), .cpu_half(cpu_half),
    .cpu_valid(cpu_valid), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_line_addr(mem_line_addr),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .cfg_ws_wr(cfg_ws_wr), .cfg_ws_wdata(cfg_ws_wdata),
    .cfg_pf_en(cfg_pf_en), .cfg_ws_rd(cfg_ws_rd)
  );

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic wait_valid(inout int lat);
    #1;
    while (!cpu_valid && lat < 300) begin
      @(negedge clk);
      if (rnd_rdy) mem_ready = ($urandom % 4) != 0;
      #1;
      lat++;
    end
  endtask

  task automatic fetch(input logic [31:0] a, input bit h, output int lat, output logic [31:0] d);
    @(negedge clk);
    cpu_req = 1'b1; cpu_addr = a; cpu_half = h;
    if (rnd_rdy) mem_ready = ($urandom % 4) != 0;
    lat = 0;
    wait_valid(lat);
    d = cpu_rdata;
  endtask

  task automatic fetch_chk(input logic [31:0] a, input bit h, input int exp_lat, input string rq);
    int lat;
    logic [31:0] d;
    fetch(a, h, lat, d);
    chk(d == exp_fetch(a, h), {rq, " data"}, 64'(d), 64'(exp_fetch(a, h)));
    if (exp_lat >= 0) chk(lat == exp_lat, {rq, " latency"}, 64'(lat), 64'(exp_lat));
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      cpu_req = 1'b0;
    end
  endtask

  task automatic set_cfg(input logic [2:0] ws, input bit pf);
    @(negedge clk);
    cpu_req = 1'b0; cfg_ws_wr = 1'b1; cfg_ws_wdata = ws; cfg_pf_en = pf;
    @(negedge clk);
    cfg_ws_wr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int lat;
    logic [31:0] d, a;
    bit h, saw_req;
    void'($urandom(32'd2024));
    rst_n = 1'b0; cpu_req = 1'b0; cpu_addr = '0; cpu_half = 1'b0;
    mem_ready = 1'b1; cfg_ws_wr = 1'b0; cfg_ws_wdata = '0; cfg_pf_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, no activity without requests
    saw_req = 1'b0;
    repeat (4) begin @(negedge clk); #1; saw_req |= mem_req; end
    chk(!cpu_valid, "R1 cpu_valid", 64'(cpu_valid), 0);
    chk(!saw_req, "R1 mem_req idle", 64'(saw_req), 0);
    chk(cfg_ws_rd == 3'd0, "R1 ws readback", 64'(cfg_ws_rd), 0);

    // R10: write while idle applies at the next edge
    set_cfg(3'd3, 1'b0); #1;
    chk(cfg_ws_rd == 3'd3, "R10 idle apply", 64'(cfg_ws_rd), 3);

    // R4, R2, R3: demand miss then same-line hits
    fetch_chk(32'h100, 1'b0, 5, "R4");
    fetch_chk(32'h104, 1'b0, 0, "R3");
    fetch_chk(32'h108, 1'b0, 0, "R3");
    fetch_chk(32'h10C, 1'b0, 0, "R2");
    saw_req = 1'b0;
    repeat (6) begin @(negedge clk); cpu_req = 1'b0; #1; saw_req |= mem_req; end
    chk(!saw_req, "R11 no prefetch when off", 64'(saw_req), 0);
    fetch_chk(32'h110, 1'b0, 5, "R11 miss");
    fetch_chk(32'h112, 1'b1, 0, "R2 half");
    fetch_chk(32'h11E, 1'b1, 0, "R2 half top");

    // R6: enabling prefetch starts next-line read
    set_cfg(3'd3, 1'b1); #1;
    chk(mem_req && mem_line_addr == 28'h12, "R6 prefetch start", 64'(mem_line_addr), 28'h12);
    idle(5);
    // R7: prefetched hit, then the following line is read
    fetch_chk(32'h120, 1'b0, 0, "R7 hit");
    idle(2); #1;
    chk(mem_req && mem_line_addr == 28'h13, "R7 next prefetch", 64'(mem_line_addr), 28'h13);

    // R8: branch aborts an in-flight prefetch
    @(negedge clk);
    cpu_req = 1'b1; cpu_addr = 32'h400; cpu_half = 1'b0;
    @(negedge clk); #1;
    chk(mem_req && mem_line_addr == 28'h40, "R8 demand addr", 64'(mem_line_addr), 28'h40);
    lat = 1;
    wait_valid(lat);
    chk(lat == 5, "R8 branch latency", 64'(lat), 5);
    chk(cpu_rdata == exp_fetch(32'h400, 1'b0), "R8 data", 64'(cpu_rdata), 64'(exp_fetch(32'h400, 1'b0)));
    idle(8);
    fetch_chk(32'h800, 1'b0, 5, "R8 branch");
    fetch_chk(32'h410, 1'b0, 5, "R8 discarded line");
    // R9: fetch of line being prefetched waits for it
    fetch_chk(32'h420, 1'b0, 4, "R9");

    // R10: write during a read is deferred
    set_cfg(3'd3, 1'b0);
    idle(6);
    @(negedge clk);
    cpu_req = 1'b1; cpu_addr = 32'hA00; cpu_half = 1'b0;
    @(negedge clk);
    cfg_ws_wr = 1'b1; cfg_ws_wdata = 3'd1;
    @(negedge clk);
    cfg_ws_wr = 1'b0; #1;
    chk(cfg_ws_rd == 3'd3, "R10 deferred", 64'(cfg_ws_rd), 3);
    lat = 2;
    wait_valid(lat);
    chk(lat == 5, "R10 old latency kept", 64'(lat), 5);
    idle(1); #1;
    chk(cfg_ws_rd == 3'd1, "R10 applied after read", 64'(cfg_ws_rd), 1);
    fetch_chk(32'hB00, 1'b0, 3, "R4 ws1");

    // R5: mem_ready low stalls completion
    @(negedge clk);
    cpu_req = 1'b1; cpu_addr = 32'hC04; cpu_half = 1'b0; mem_ready = 1'b0;
    repeat (6) @(negedge clk);
    #1;
    chk(!cpu_valid && mem_req, "R5 stalled", 64'({cpu_valid, mem_req}), 64'h1);
    mem_ready = 1'b1;
    @(negedge clk); #1;
    chk(cpu_valid && cpu_rdata == exp_fetch(32'hC04, 1'b0), "R5 completes", 64'(cpu_rdata), 64'(exp_fetch(32'hC04, 1'b0)));

    // R12: zero wait states, prefetch off and on
    set_cfg(3'd0, 1'b0);
    idle(2);
    fetch_chk(32'hE00, 1'b0, 2, "R12 off miss");
    fetch_chk(32'hE06, 1'b1, 0, "R12 off hit");
    set_cfg(3'd0, 1'b1);
    idle(2);
    fetch_chk(32'hF00, 1'b0, 2, "R12 on miss");
    fetch_chk(32'hF04, 1'b0, -1, "R12");
    fetch_chk(32'hF08, 1'b0, -1, "R12");
    fetch_chk(32'hF0C, 1'b0, -1, "R12");
    fetch_chk(32'hF10, 1'b0, 0, "R12 on prefetched");

    // Random mix, all requirements on data (R12 and R2 in particular)
    rnd_rdy = 1'b1;
    a = 32'h2000;
    for (int i = 0; i < 400; i++) begin
      if ($urandom % 16 == 0) set_cfg(3'($urandom % 4), 1'($urandom % 2));
      h = 1'($urandom % 2);
      if ($urandom % 4 == 0) a = $urandom % 32'h10000;
      else a = a + (h ? 32'd2 : 32'd4);
      a = h ? (a & ~32'h1) : (a & ~32'h3);
      fetch(a, h, lat, d);
      chk(d == exp_fetch(a, h), "R2 random data", 64'(d), 64'(exp_fetch(a, h)));
    end
    rnd_rdy = 1'b0;
    mem_ready = 1'b1;
    idle(2);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule